// File: doc/BRIEF.md
# Memory Device Boundary Test Port

This block is the serial test port of a memory device. It holds the sixteen-state test controller, a three-bit instruction register, a one-bit bypass stage, a 32-bit identity word and a boundary chain whose length is a parameter. All of it runs on the test clock. An active-low power-on reset takes the controller to Test-Logic-Reset, so the block needs no separate test reset pin. The pad pull-ups that make an open mode or data pin read as 1 belong to the pin cells and are not part of this block.

The instruction register decodes eight codes. Three of them pick the boundary chain. One picks the identity word. The remaining four pick bypass. The two codes for external test and for floating sample also raise the data-pin float and terminator-off controls. The ordinary sample code leaves both controls low. The boundary chain loads a parallel capture bus and drives a parallel update bus. The pin cells and the memory array lie outside the block. Every port is a plain level signal, so there is no valid/ready handshake and nothing can stall a scan.

Top module: `scan_port`

## Requirements
- R1: While `por_n` is low and just after it is released, the controller is in Test-Logic-Reset, the active instruction is the identity code 3'b001, `tdo_en`, `pins_hiz_o`, `term_off_o` and `bsr_sel_o` are 0, and `bsr_upd_o` is all zeros.
- R2: Five rising edges of `tck` with `tms` high bring the controller to Test-Logic-Reset from any state. One more edge there reloads the identity instruction.
- R3: In Capture-IR the instruction shift stage loads 3'b001. Shift-IR shifts it out least significant bit first, with `tdi` entering at the top bit.
- R4: Codes 3'b000, 3'b010 and 3'b100 select the boundary chain (`bsr_sel_o`=1), which is exactly BSR_LEN bits long. Code 3'b001 selects the identity word. Codes 3'b011, 3'b101, 3'b110 and 3'b111 select bypass.
- R5: The bypass stage loads 0 in Capture-DR and delays `tdi` by one shift.
- R6: The identity word reads, least significant bit first: bit 0 = 1, bits [11:1] manufacturer code, [17:12] vendor field, [27:18] part configuration, [31:28] revision.
- R7: When the boundary chain is selected, Capture-DR loads `bsr_cap_i` and Update-DR copies the shifted chain to `bsr_upd_o`. In every other case `bsr_upd_o` holds its value.
- R8: `pins_hiz_o` and `term_off_o` are 1 exactly for codes 3'b000 and 3'b010.
- R9: `tdo` and `tdo_en` change on the falling edge of `tck`. `tdo_en` is 1 only in Shift-IR and Shift-DR.
- R10: A new instruction takes effect only at the Update-IR edge. Shifting a new code leaves the controls unchanged until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Device power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| bsr_cap_i | input | BSR_LEN | Parallel values captured into the boundary chain |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | Output enable for `tdo`; high only while shifting |
| bsr_upd_o | output | BSR_LEN | Boundary update register toward the pin cells |
| pins_hiz_o | output | 1 | Float the data pins |
| term_off_o | output | 1 | Switch off the input terminators |
| bsr_sel_o | output | 1 | Boundary chain is the selected data register |

## Verification
The assertions assume that `tms` and `tdi` change only away from the rising edge, and that `bsr_cap_i` stays steady from Select-DR to Capture-DR. The bench therefore moves every input half a cycle after a falling edge and loads a new capture value only while the controller idles in Run-Test-Idle. The stimulus also assumes no reset pulse inside a scan: `por_n` is released once, and later resets come only from five TMS-high edges.

// File: rtl/scan_port_pkg.sv
`timescale 1ns/1ps
package scan_port_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST   = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE   = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE_Z = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 3'b100;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 3'b001;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_BOUNDARY} dr_sel_e;

  typedef struct packed {
    dr_sel_e sel;
    logic    hiz;
    logic    term_off;
  } instr_ctl_t;

  function automatic instr_ctl_t decode_instr(logic [IR_W-1:0] op);
    instr_ctl_t c;
    c = '{sel: DR_BYPASS, hiz: 1'b0, term_off: 1'b0};
    case (op)
      OP_EXTEST, OP_SAMPLE_Z: begin
        c.sel = DR_BOUNDARY;
        c.hiz = 1'b1;
        c.term_off = 1'b1;
      end
      OP_SAMPLE: c.sel = DR_BOUNDARY;
      OP_IDCODE: c.sel = DR_IDENT;
      default:   c.sel = DR_BYPASS;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/scan_fsm.sv
`timescale 1ns/1ps
module scan_fsm
  import scan_port_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    unique case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= ST_TLR;
    else        state <= nxt;
  end

  // Run of consecutive TMS-high edges, saturating at five.
  logic [2:0] ones_q;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)    ones_q <= 3'd0;
    else if (!tms) ones_q <= 3'd0;
    else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
  end

  // R2: five high TMS edges always end in Test-Logic-Reset
  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!por_n)
    (ones_q == 3'd5) |-> (state == ST_TLR));

endmodule

// File: rtl/scan_ir.sv
`timescale 1ns/1ps
module scan_ir
  import scan_port_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic            ir_tdo,
  output dr_sel_e         dr_sel,
  output logic            pins_hiz,
  output logic            term_off
);

  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] instr_q;
  instr_ctl_t      ctl;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      ir_sr   <= IR_CAPTURE;
      instr_q <= OP_IDCODE;
    end else begin
      case (state)
        ST_CAP_IR: ir_sr   <= IR_CAPTURE;
        ST_SH_IR:  ir_sr   <= {tdi, ir_sr[IR_W-1:1]};
        ST_UPD_IR: instr_q <= ir_sr;
        ST_TLR:    instr_q <= OP_IDCODE;
        default:   ;
      endcase
    end
  end

  always_comb ctl = decode_instr(instr_q);

  assign ir_tdo   = ir_sr[0];
  assign dr_sel   = ctl.sel;
  assign pins_hiz = ctl.hiz;
  assign term_off = ctl.term_off;

  // R3: capture pattern present right after Capture-IR
  a_r3_ir_capture: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_CAP_IR) |=> (ir_sr == 3'b001));

  // R10: the active instruction moves only on Update-IR or in reset state
  a_r10_instr_hold: assert property (@(posedge tck) disable iff (!por_n)
    (state != ST_UPD_IR && state != ST_TLR) |=> $stable(instr_q));

endmodule

// File: rtl/scan_dr.sv
`timescale 1ns/1ps
module scan_dr
  import scan_port_pkg::*;
#(
  parameter int          BSR_LEN    = 74,
  parameter logic [3:0]  REV_ID     = 4'h0,
  parameter logic [9:0]  PART_CFG   = 10'h155,
  parameter logic [5:0]  VENDOR_DEF = 6'h00,
  parameter logic [10:0] MFR_CODE   = 11'h2A5
)(
  input  logic               tck,
  input  logic               por_n,
  input  logic               tdi,
  input  tap_state_e         state,
  input  dr_sel_e            dr_sel,
  input  logic [BSR_LEN-1:0] bsr_cap_i,
  output logic [BSR_LEN-1:0] bsr_upd_o,
  output logic               dr_tdo
);

  localparam int ID_W = $bits(REV_ID) + $bits(PART_CFG) + $bits(VENDOR_DEF)
                      + $bits(MFR_CODE) + 1;
  localparam logic [ID_W-1:0] ID_WORD = {REV_ID, PART_CFG, VENDOR_DEF, MFR_CODE, 1'b1};

  logic               byp_q;
  logic [ID_W-1:0]    id_sr;
  logic [BSR_LEN-1:0] bsr_sr;
  logic [BSR_LEN-1:0] bsr_upd_q;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      byp_q     <= 1'b0;
      id_sr     <= '0;
      bsr_sr    <= '0;
      bsr_upd_q <= '0;
    end else if (state == ST_CAP_DR) begin
      case (dr_sel)
        DR_BYPASS:   byp_q  <= 1'b0;
        DR_IDENT:    id_sr  <= ID_WORD;
        DR_BOUNDARY: bsr_sr <= bsr_cap_i;
        default:     ;
      endcase
    end else if (state == ST_SH_DR) begin
      case (dr_sel)
        DR_BYPASS:   byp_q  <= tdi;
        DR_IDENT:    id_sr  <= {tdi, id_sr[ID_W-1:1]};
        DR_BOUNDARY: bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
        default:     ;
      endcase
    end else if (state == ST_UPD_DR && dr_sel == DR_BOUNDARY) begin
      bsr_upd_q <= bsr_sr;
    end
  end

  always_comb begin
    case (dr_sel)
      DR_IDENT:    dr_tdo = id_sr[0];
      DR_BOUNDARY: dr_tdo = bsr_sr[0];
      default:     dr_tdo = byp_q;
    endcase
  end

  assign bsr_upd_o = bsr_upd_q;

  // R5: bypass stage holds 0 after its capture
  a_r5_bypass_zero: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_CAP_DR && dr_sel == DR_BYPASS) |=> !byp_q);

  // R7: the update bus moves only on Update-DR with the chain selected
  a_r7_update_hold: assert property (@(posedge tck) disable iff (!por_n)
    !(state == ST_UPD_DR && dr_sel == DR_BOUNDARY) |=> $stable(bsr_upd_q));

endmodule

// File: rtl/scan_port.sv
`timescale 1ns/1ps
module scan_port
  import scan_port_pkg::*;
#(
  parameter int          BSR_LEN    = 74,
  parameter logic [3:0]  REV_ID     = 4'h0,
  parameter logic [9:0]  PART_CFG   = 10'h155,
  parameter logic [5:0]  VENDOR_DEF = 6'h00,
  parameter logic [10:0] MFR_CODE   = 11'h2A5
)(
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] bsr_cap_i,
  output logic               tdo,
  output logic               tdo_en,
  output logic [BSR_LEN-1:0] bsr_upd_o,
  output logic               pins_hiz_o,
  output logic               term_off_o,
  output logic               bsr_sel_o
);

  tap_state_e state;
  dr_sel_e    dr_sel;
  logic       ir_tdo;
  logic       dr_tdo;

  scan_fsm u_fsm (
    .tck   (tck),
    .por_n (por_n),
    .tms   (tms),
    .state (state)
  );

  scan_ir u_ir (
    .tck      (tck),
    .por_n    (por_n),
    .tdi      (tdi),
    .state    (state),
    .ir_tdo   (ir_tdo),
    .dr_sel   (dr_sel),
    .pins_hiz (pins_hiz_o),
    .term_off (term_off_o)
  );

  scan_dr #(
    .BSR_LEN    (BSR_LEN),
    .REV_ID     (REV_ID),
    .PART_CFG   (PART_CFG),
    .VENDOR_DEF (VENDOR_DEF),
    .MFR_CODE   (MFR_CODE)
  ) u_dr (
    .tck       (tck),
    .por_n     (por_n),
    .tdi       (tdi),
    .state     (state),
    .dr_sel    (dr_sel),
    .bsr_cap_i (bsr_cap_i),
    .bsr_upd_o (bsr_upd_o),
    .dr_tdo    (dr_tdo)
  );

  assign bsr_sel_o = (dr_sel == DR_BOUNDARY);

  // Serial output retimed to the falling edge.
  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else if (state == ST_SH_IR) begin
      tdo    <= ir_tdo;
      tdo_en <= 1'b1;
    end else if (state == ST_SH_DR) begin
      tdo    <= dr_tdo;
      tdo_en <= 1'b1;
    end else begin
      tdo_en <= 1'b0;
    end
  end

  // R9: output enable seen at a rising edge only inside a shift state
  a_r9_enable_in_shift: assert property (@(posedge tck) disable iff (!por_n)
    tdo_en |-> (state == ST_SH_DR || state == ST_SH_IR));

endmodule

// File: tb/scan_port_bench.sv
`timescale 1ns/1ps
module scan_port_bench;

  localparam int BSR_LEN = 74;
  localparam logic [31:0] EXP_ID = {4'h3, 10'h2C6, 6'h15, 11'h1B3, 1'b1};
  localparam logic [127:0] BSR_MASK = (128'd1 << BSR_LEN) - 128'd1;

  logic tck = 1'b0;
  logic por_n;
  logic tms;
  logic tdi;
  logic [BSR_LEN-1:0] cap_bus;
  logic tdo, tdo_en, pins_hiz, term_off, bsr_sel;
  logic [BSR_LEN-1:0] upd_bus;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 tck = ~tck;

  scan_port #(
    .BSR_LEN(BSR_LEN), .REV_ID(4'h3), .PART_CFG(10'h2C6),
    .VENDOR_DEF(6'h15), .MFR_CODE(11'h1B3)
  ) u_scan_port (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .bsr_cap_i(cap_bus),
    .tdo(tdo), .tdo_en(tdo_en), .bsr_upd_o(upd_bus),
    .pins_hiz_o(pins_hiz), .term_off_o(term_off), .bsr_sel_o(bsr_sel)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int exp_sel(logic [2:0] c);
    if (c == 3'b000 || c == 3'b010 || c == 3'b100) return 0;
    if (c == 3'b001) return 1;
    return 2;
  endfunction

  function automatic logic exp_hiz(logic [2:0] c);
    return (c == 3'b000 || c == 3'b010);
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  // Sample outputs half a cycle before the next rising edge, then drive.
  task automatic tick(input logic m, input logic d, output logic o, output logic e);
    @(negedge tck);
    #1;
    o = tdo;
    e = tdo_en;
    tms = m;
    tdi = d;
  endtask

  task automatic scan(input bit ir, input int n, input logic [127:0] din,
                      output logic [127:0] dout, output logic all_en, output logic exit_en);
    logic o, e;
    dout = '0;
    all_en = 1'b1;
    tick(1'b1, 1'b1, o, e);
    if (ir) tick(1'b1, 1'b1, o, e);
    tick(1'b0, 1'b1, o, e);
    tick(1'b0, 1'b1, o, e);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], o, e);
      dout[i] = o;
      all_en = all_en & e;
    end
    tick(1'b1, 1'b1, o, exit_en);
    tick(1'b0, 1'b1, o, e);
    tick(1'b0, 1'b1, o, e);
  endtask

  task automatic run_code(input logic [2:0] code);
    logic [127:0] d, din, prev;
    logic ae, xe;
    scan(1'b1, 3, {125'd0, code}, d, ae, xe);
    chk("R3 ir capture", d[2:0], 3'b001);
    chk("R8 float", pins_hiz, exp_hiz(code));
    chk("R8 term", term_off, exp_hiz(code));
    chk("R4 chain select", bsr_sel, exp_sel(code) == 0);
    prev = upd_bus;
    case (exp_sel(code))
      0: begin
        cap_bus = rnd128() & BSR_MASK;
        din = rnd128() & BSR_MASK;
        scan(1'b0, BSR_LEN, din, d, ae, xe);
        chk("R7 capture", d & BSR_MASK, cap_bus);
        chk("R7 update", upd_bus, din);
      end
      1: begin
        din = rnd128();
        scan(1'b0, 32, din, d, ae, xe);
        chk("R6 id word", d[31:0], EXP_ID);
        chk("R7 hold id", upd_bus, prev);
      end
      default: begin
        din = rnd128();
        scan(1'b0, 8, din, d, ae, xe);
        chk("R5 bypass", d[7:0], {din[6:0], 1'b0});
        chk("R7 hold bypass", upd_bus, prev);
      end
    endcase
  endtask

  initial begin
    logic [127:0] d, din;
    logic o, e, ae, xe;
    void'($urandom(32'h5EED));
    por_n = 1'b0;
    tms = 1'b1;
    tdi = 1'b1;
    cap_bus = '0;
    repeat (3) @(negedge tck);
    #1;
    chk("R1 tdo_en", tdo_en, 1'b0);
    chk("R1 float", pins_hiz, 1'b0);
    chk("R1 term", term_off, 1'b0);
    chk("R1 chain sel", bsr_sel, 1'b0);
    chk("R1 update", upd_bus, '0);
    por_n = 1'b1;
    tick(1'b0, 1'b1, o, e);
    scan(1'b0, 32, 128'h0, d, ae, xe);
    chk("R1 identity after reset", d[31:0], EXP_ID);
    chk("R9 enable while shifting", ae, 1'b1);
    chk("R9 enable off at exit", xe, 1'b0);

    for (int c = 0; c < 8; c++) run_code(c[2:0]);
    for (int k = 0; k < 24; k++) run_code(3'($urandom() % 8));

    // R4: chain length is exactly BSR_LEN
    scan(1'b1, 3, 128'h0, d, ae, xe);
    din = rnd128() & ((128'd1 << (BSR_LEN + 8)) - 128'd1);
    scan(1'b0, BSR_LEN + 8, din, d, ae, xe);
    chk("R4 chain length", d[BSR_LEN +: 8], din[7:0]);

    // R10: controls follow the old code until Update-IR
    scan(1'b1, 3, 128'h0, d, ae, xe);
    tick(1'b1, 1'b1, o, e);
    tick(1'b1, 1'b1, o, e);
    tick(1'b0, 1'b1, o, e);
    tick(1'b0, 1'b1, o, e);
    tick(1'b0, 1'b1, o, e);
    tick(1'b0, 1'b1, o, e);
    tick(1'b1, 1'b1, o, e);
    tick(1'b1, 1'b1, o, e);
    chk("R10 old code in exit", pins_hiz, 1'b1);
    chk("R9 no enable in exit", e, 1'b0);
    tick(1'b0, 1'b1, o, e);
    chk("R10 old code in update", pins_hiz, 1'b1);
    tick(1'b0, 1'b1, o, e);
    chk("R10 new code after update", pins_hiz, 1'b0);
    chk("R10 bypass selected", bsr_sel, 1'b0);

    // R2: five high TMS edges from Shift-DR reset and reload identity
    scan(1'b1, 3, 128'h2, d, ae, xe);
    tick(1'b1, 1'b1, o, e);
    tick(1'b0, 1'b1, o, e);
    tick(1'b0, 1'b1, o, e);
    for (int j = 0; j < 5; j++) tick(1'b1, 1'b1, o, e);
    tick(1'b0, 1'b1, o, e);
    tick(1'b0, 1'b1, o, e);
    chk("R2 float cleared", pins_hiz, 1'b0);
    chk("R2 chain deselected", bsr_sel, 1'b0);
    scan(1'b0, 32, 128'h0, d, ae, xe);
    chk("R2 identity reloaded", d[31:0], EXP_ID);

    // R2: random walks followed by a TMS-high run
    for (int w = 0; w < 4; w++) begin
      scan(1'b1, 3, 128'h7, d, ae, xe);
      for (int s = 0; s < 30; s++) tick(1'($urandom()), 1'($urandom()), o, e);
      for (int j = 0; j < 5; j++) tick(1'b1, 1'b1, o, e);
      tick(1'b0, 1'b1, o, e);
      tick(1'b0, 1'b1, o, e);
      scan(1'b0, 32, 128'h0, d, ae, xe);
      chk("R2 identity after walk", d[31:0], EXP_ID);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

endmodule